// File: doc/BRIEF.md
# Target Data-Phase Wait Controller

This block sits beside the target side of a bus interface. For every data phase aimed at the target, it chooses one of three outcomes. The phase can complete now. It can be stretched with wait states, which means target-ready is held low. Or it can be ended by a target-initiated stop, also called a disconnect. The decision depends on the resource the phase addresses:

- the receive buffer, which the host reads;
- the transmit buffer, which the host writes;
- the command-vector register, which the host writes;
- any other register, which is always ready.

The data phase is a valid/ready stream. `phase_valid` is the initiator's valid, and `trdy` is the target's ready. A transfer takes place in a cycle where both are high. While the addressed resource is blocked, `trdy` stays low, which is the back-pressure. The initiator must keep `phase_valid` and `phase_kind` steady until it sees `trdy` or `stop`.

In the bus mode that carries the wait policy, the controller inserts at most a fixed number of wait states (eight by default) and then issues a stop. A wait-disable bit in a small 32-bit control register changes this to a stop in the first blocked cycle. The same register holds three semaphore bits. Hosts use them only for their own arbitration, and they do not affect the controller. In the other bus mode, the wait-disable bit is ignored, no stop is ever raised, and a blocked phase simply waits.

Top module: `twc_target_wait`

## Requirements
- R1: With `host_mode_pci`=1 and the addressed resource ready, `trdy` is 1 in the same cycle as `phase_valid` and `stop` is 0. `phase_kind` encoding: 00 other register (always ready), 01 receive-buffer read, 10 transmit-buffer write, 11 command-vector write.
- R2: A receive-buffer read while `rx_avail`=0 holds `trdy` low. `trdy` rises in the first cycle in which `rx_avail` is 1.
- R3: A transmit-buffer write while `tx_full`=1 holds `trdy` low. `trdy` rises in the first cycle in which `tx_full` is 0.
- R4: A command-vector write while `cmd_busy`=1 holds `trdy` low. `trdy` rises in the first cycle in which `cmd_busy` is 0. This includes the ninth cycle of the phase.
- R5: In PCI mode with wait-disable clear, a phase that stays blocked gets exactly eight wait cycles. On the ninth blocked cycle `stop` is 1 and `trdy` is 0. `trdy` and `stop` are never high together.
- R6: Once raised, `stop` stays high up to and including the cycle in which `txn_end` is 1, and it is 0 from the next cycle on.
- R7: In PCI mode with wait-disable set, `stop` rises in the first blocked cycle of a phase, with no wait states.
- R8: With `host_mode_pci`=0, the wait-disable bit has no effect and `stop` stays 0. A blocked phase waits for any number of cycles, then completes with `trdy`.
- R9: The control register is written with `ctl_wr_en`/`ctl_wr_data`. The new value appears on `ctl_rd_data` one cycle later. Bit 19 is wait-disable and bits 16..14 are the semaphores. All of these reset to 0.
- R10: Bits 31..20 and 18..17 of `ctl_rd_data` always read 0, whatever was written to them. So do bits 13..0.
- R11: The semaphore bits do not change `trdy` or `stop`.
- R12: The wait count restarts for every data phase. A phase that follows a completed, stretched phase again gets the full eight wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mode_pci | input | 1 | 1 selects the bus mode with the wait/stop policy |
| phase_valid | input | 1 | Initiator has a data phase pending to this target |
| phase_kind | input | 2 | Addressed resource (encoding in R1) |
| txn_end | input | 1 | Initiator ends the current transaction |
| rx_avail | input | 1 | Receive buffer holds data |
| tx_full | input | 1 | Transmit buffer is full |
| cmd_busy | input | 1 | A host command is still pending |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control register write value |
| ctl_rd_data | output | 32 | Control register contents |
| trdy | output | 1 | Target ready; the data phase completes |
| stop | output | 1 | Target-initiated stop/disconnect |

## Verification
A wait counter that was not cleared between phases would show up as a stop raised too early in the next phase. That error becomes visible within at most nine cycles of a blocked phase, and the R12 sequence checks that exact cycle. A stop-hold flag that was lost or stuck would show as `stop` dropping before `txn_end`, or staying high after it, and either case is seen in the very next cycle. A wrong control-register bit shows up in `ctl_rd_data` one cycle after the write. A wrong wait-disable bit shows up as a stop that comes on the first blocked cycle when it should not, or does not come when it should.

// File: rtl/twc_pkg.sv
package twc_pkg;

  typedef enum logic [1:0] {
    PH_OTHER     = 2'b00,
    PH_RX_READ   = 2'b01,
    PH_TX_WRITE  = 2'b10,
    PH_CMD_WRITE = 2'b11
  } phase_kind_e;

  localparam int CTL_W   = 32;
  localparam int WDIS_BIT = 19;
  localparam int SEM_LO  = 14;
  localparam int SEM_W   = 3;

endpackage

// File: rtl/twc_ctl_reg.sv
module twc_ctl_reg #(
  parameter int REG_W  = twc_pkg::CTL_W,
  parameter int WD_BIT = twc_pkg::WDIS_BIT,
  parameter int SM_LO  = twc_pkg::SEM_LO,
  parameter int SM_W   = twc_pkg::SEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             wait_dis,
  output logic [REG_W-1:0] rd_data
);
  localparam int SM_HI = SM_LO + SM_W - 1;

  logic            wd_q;
  logic [SM_W-1:0] sem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q  <= 1'b0;
      sem_q <= '0;
    end else if (wr_en) begin
      wd_q  <= wr_data[WD_BIT];
      sem_q <= wr_data[SM_HI:SM_LO];
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[WD_BIT]      = wd_q;
    rd_data[SM_HI:SM_LO] = sem_q;
  end

  assign wait_dis = wd_q;

  // R9: a write lands in the register one cycle later
  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wait_dis == $past(wr_data[WD_BIT])));

endmodule

// File: rtl/twc_resource_sel.sv
module twc_resource_sel (
  input  logic [1:0] kind,
  input  logic       rx_avail,
  input  logic       tx_full,
  input  logic       cmd_busy,
  output logic       res_ready
);
  import twc_pkg::*;

  phase_kind_e k;
  assign k = phase_kind_e'(kind);

  always_comb begin
    unique case (k)
      PH_RX_READ:   res_ready = rx_avail;
      PH_TX_WRITE:  res_ready = ~tx_full;
      PH_CMD_WRITE: res_ready = ~cmd_busy;
      default:      res_ready = 1'b1;
    endcase
  end

endmodule

// File: rtl/twc_wait_timer.sv
module twc_wait_timer #(
  parameter int WAIT_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pci_mode,
  input  logic wait_dis,
  input  logic phase_valid,
  input  logic res_ready,
  input  logic txn_end,
  output logic trdy,
  output logic stop
);
  localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_LIMIT);

  logic [CNT_W-1:0] wait_cnt;
  logic             stop_hold;
  logic             blocked;
  logic             stop_now;
  logic             limit_hit;

  assign limit_hit = (wait_cnt == LIMIT);
  assign blocked   = phase_valid & ~res_ready & ~stop_hold;
  assign stop_now  = pci_mode & blocked & (wait_dis | limit_hit);
  assign trdy      = phase_valid & res_ready & ~stop_hold;
  assign stop      = stop_hold | stop_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_hold <= 1'b0;
    end else if (txn_end) begin
      stop_hold <= 1'b0;
    end else if (stop_now) begin
      stop_hold <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (!phase_valid || trdy || stop_now || stop_hold || txn_end) begin
      wait_cnt <= '0;
    end else if (blocked && !limit_hit) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assert_trdy_stop_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(trdy && stop));

  assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= LIMIT);

  assert_trdy_needs_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trdy |-> res_ready);

  assert_stop_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !txn_end) |=> stop);

  assert_stop_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !stop_now) |=> !stop_hold);

  assert_immediate_disc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_mode && wait_dis && phase_valid && !res_ready) |-> stop);

  assert_no_stop_off_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_mode && !stop_hold) |-> !stop);

endmodule

// File: rtl/twc_target_wait.sv
module twc_target_wait #(
  parameter int WAIT_LIMIT = 8,
  parameter int REG_W      = twc_pkg::CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode_pci,
  input  logic             phase_valid,
  input  logic [1:0]       phase_kind,
  input  logic             txn_end,
  input  logic             rx_avail,
  input  logic             tx_full,
  input  logic             cmd_busy,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wr_data,
  output logic [REG_W-1:0] ctl_rd_data,
  output logic             trdy,
  output logic             stop
);
  logic wait_dis;
  logic res_ready;

  twc_ctl_reg #(.REG_W(REG_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .wait_dis(wait_dis),
    .rd_data (ctl_rd_data)
  );

  twc_resource_sel u_sel (
    .kind     (phase_kind),
    .rx_avail (rx_avail),
    .tx_full  (tx_full),
    .cmd_busy (cmd_busy),
    .res_ready(res_ready)
  );

  twc_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .pci_mode   (host_mode_pci),
    .wait_dis   (wait_dis),
    .phase_valid(phase_valid),
    .res_ready  (res_ready),
    .txn_end    (txn_end),
    .trdy       (trdy),
    .stop       (stop)
  );

  // R10: reserved positions never read back as one
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data[31:20] == '0) && (ctl_rd_data[18:17] == '0) && (ctl_rd_data[13:0] == '0));

endmodule

// File: tb/test_twc_target_wait.sv
module test_twc_target_wait;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode_pci = 1'b1;
  logic        phase_valid = 1'b0;
  logic [1:0]  phase_kind = 2'b00;
  logic        txn_end = 1'b0;
  logic        rx_avail = 1'b0;
  logic        tx_full = 1'b0;
  logic        cmd_busy = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic [31:0] ctl_rd_data;
  logic        trdy;
  logic        stop;

  always #10 clk = ~clk;

  twc_target_wait i_twc_target_wait (
    .clk(clk), .rst_n(rst_n), .host_mode_pci(host_mode_pci),
    .phase_valid(phase_valid), .phase_kind(phase_kind), .txn_end(txn_end),
    .rx_avail(rx_avail), .tx_full(tx_full), .cmd_busy(cmd_busy),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .trdy(trdy), .stop(stop)
  );

  typedef struct {
    logic        t;
    logic        s;
    logic [31:0] rd;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          vectors = 0;
  int          miscompares = 0;
  logic [31:0] shadow = '0;
  bit          done = 1'b0;

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      vectors++;
      if (trdy !== it.t || stop !== it.s || ctl_rd_data !== it.rd) begin
        miscompares++;
        $display("FAIL %s: trdy/stop/rd actual %b/%b/%h expected %b/%b/%h",
                 it.tag, trdy, stop, ctl_rd_data, it.t, it.s, it.rd);
      end
    end
  end

  task automatic push(input logic t, input logic s, input string tag);
    item_t it;
    it.t = t; it.s = s; it.rd = shadow; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic rx,
                      input logic txf, input logic cb, input logic te,
                      input logic et, input logic es, input string tag);
    @(posedge clk); #2;
    phase_valid = v; phase_kind = k; rx_avail = rx; tx_full = txf;
    cmd_busy = cb; txn_end = te; ctl_wr_en = 1'b0;
    push(et, es, tag);
  endtask

  task automatic wr_ctl(input logic [31:0] d, input string tag);
    @(posedge clk); #2;
    phase_valid = 1'b0; txn_end = 1'b0;
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    push(1'b0, 1'b0, tag);
    shadow = d & 32'h0009_C000;   // R9/R10: only bit 19 and bits 16..14 stored
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // reset state (R9)
    @(posedge clk); #2; push(1'b0, 1'b0, "R9 reset");
    @(posedge clk); #2; push(1'b0, 1'b0, "R9 reset");
    rst_n = 1'b1;

    // R9, R10: register write and read-back
    wr_ctl(32'hFFFF_FFFF, "R9 write all ones");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R10 reserved read zero");
    wr_ctl(32'h0001_4000, "R9 semaphores");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R11 semaphores held");

    // R1: ready resources complete at once
    step(1, 2'b00, 0, 0, 0, 0, 1, 0, "R1 other register");
    step(1, 2'b01, 1, 0, 0, 0, 1, 0, "R1 rx ready");
    step(1, 2'b10, 0, 0, 0, 0, 1, 0, "R1 tx room");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R1 idle");

    // R2: rx empty waits, completes when data arrives
    for (int i = 0; i < 3; i++) step(1, 2'b01, 0, 0, 0, 0, 0, 0, "R2 rx wait");
    step(1, 2'b01, 1, 0, 0, 0, 1, 0, "R2 rx arrives");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R2 idle");

    // R3: tx full waits
    for (int i = 0; i < 5; i++) step(1, 2'b10, 0, 1, 0, 0, 0, 0, "R3 tx wait");
    step(1, 2'b10, 0, 0, 0, 0, 1, 0, "R3 tx drains");

    // R4: cmd pending, freed on the ninth cycle
    for (int i = 0; i < 8; i++) step(1, 2'b11, 0, 0, 1, 0, 0, 0, "R4 cmd wait");
    step(1, 2'b11, 0, 0, 0, 0, 1, 0, "R4 cmd ninth cycle");

    // R12 + R5: next phase gets eight full waits, then stop
    for (int i = 0; i < 8; i++) step(1, 2'b11, 0, 0, 1, 0, 0, 0, "R12 fresh wait count");
    step(1, 2'b11, 0, 0, 1, 0, 0, 1, "R5 stop after eight");
    // R6: held until txn_end
    step(1, 2'b11, 0, 0, 0, 0, 0, 1, "R6 held though ready");
    step(0, 2'b00, 0, 0, 0, 0, 0, 1, "R6 held");
    step(0, 2'b00, 0, 0, 0, 1, 0, 1, "R6 txn_end cycle");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R6 released");

    // R7: wait-disable gives an immediate stop
    wr_ctl(32'h0009_4000, "R7 set wait-disable");
    step(1, 2'b10, 0, 1, 0, 0, 0, 1, "R7 immediate stop");
    step(1, 2'b10, 0, 1, 0, 0, 0, 1, "R7 held");
    step(0, 2'b00, 0, 0, 0, 1, 0, 1, "R7 end");
    step(1, 2'b01, 1, 0, 0, 0, 1, 0, "R7 ready completes");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R7 idle");

    // R8: other bus mode ignores wait-disable and never stops
    host_mode_pci = 1'b0;
    for (int i = 0; i < 12; i++) step(1, 2'b01, 0, 0, 0, 0, 0, 0, "R8 endless wait");
    step(1, 2'b01, 1, 0, 0, 0, 1, 0, "R8 completes");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R8 idle");
    host_mode_pci = 1'b1;

    // R5 on rx with wait-disable clear, semaphores set (R11)
    wr_ctl(32'h0001_C000, "R11 semaphores only");
    for (int i = 0; i < 8; i++) step(1, 2'b01, 0, 0, 0, 0, 0, 0, "R11 waits unaffected");
    step(1, 2'b01, 0, 0, 0, 0, 0, 1, "R5 rx stop");
    step(0, 2'b00, 0, 0, 0, 1, 0, 1, "R6 end");
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, "R6 released");

    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule